// File: doc/BRIEF.md
# Eight-Bit Multifunction ALU

This block is a purely combinational arithmetic and logic unit for a small datapath. Two 8-bit operands enter it. An arithmetic-enable input picks between two result sources. The first source is a single adder whose second operand is either the B operand or its bitwise complement. The second source is a bitwise logic stage. That stage uses a 4-bit function code as a truth table, so it can produce any of the sixteen two-input boolean functions.

The adder's carry-in comes from a 2-bit mode code. The code chooses among an externally held carry flag, the complement of that flag, a constant 0 and a constant 1. This covers add, add-with-carry, subtract (complement B with a carry-in of 1) and subtract-with-borrow.

Beside the result, the block drives three flags: the adder carry out, a sign flag and a zero flag. It has no storage. Every output follows its inputs within the same cycle.

Top module: `mf_alu`

## Requirements
- R1: With cin_mode = 2'b00 the adder carry-in equals carry_flag.
- R2: With cin_mode = 2'b01 the adder carry-in equals the complement of carry_flag.
- R3: With cin_mode = 2'b10 the adder carry-in is 0, whatever carry_flag holds.
- R4: With cin_mode = 2'b11 the adder carry-in is 1, whatever carry_flag holds.
- R5: With arith_en = 1, result equals (a_op + B' + carry-in) mod 256. B' is b_op when sub_en = 0 and ~b_op when sub_en = 1. With sub_en = 1 and cin_mode = 2'b11 the result is a_op − b_op.
- R6: carry_out is bit 8 of a_op + B' + carry-in, and it holds in both settings of arith_en.
- R7: With arith_en = 0, each bit i of result equals func_tt[{b_op[i], a_op[i]}], with b_op[i] as the upper index bit.
- R8: In logic mode the function codes act as follows: 4'b1000 gives AND, 4'b1110 gives OR, 4'b0110 gives XOR, 4'b1010 passes a_op, and 4'b0101 gives ~a_op.
- R9: neg_flag always equals result[7].
- R10: zero_flag is 1 exactly when all eight bits of result are 0.
- R11: The boundary cases behave as follows. 8'hFF + 8'h01 with a carry-in of 0 gives result 8'h00, carry_out 1 and zero_flag 1. 8'h00 − 8'h01 gives result 8'hFF, carry_out 0 and neg_flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_op | input | 8 | First operand |
| b_op | input | 8 | Second operand |
| carry_flag | input | 1 | Stored carry flag supplied from outside |
| cin_mode | input | 2 | Adder carry-in source: flag, inverted flag, 0, 1 |
| sub_en | input | 1 | 1 feeds ~b_op to the adder, 0 feeds b_op |
| arith_en | input | 1 | 1 routes the adder sum to result, 0 routes the logic stage |
| func_tt | input | 4 | Truth table for the logic stage |
| result | output | 8 | Selected result |
| carry_out | output | 1 | Adder carry out |
| neg_flag | output | 1 | Sign bit of result |
| zero_flag | output | 1 | High when result is all zeros |

## Verification
The carry-out in logic mode is the hardest case to reach, because the adder keeps working even though its sum is not shown on the result. Logic-mode items therefore use operands and carry-in modes chosen to make the hidden carry 1, and the bench compares carry_out against its model there. The carry-in modes are also hard to tell apart. Each mode is driven with carry_flag at both values on operands such as 8'hFF + 8'h00, where the carry-in alone decides both the sum and the carry out.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned ALU_W = 8;

  typedef enum logic [1:0] {
    CIN_FLAG = 2'b00,
    CIN_INV  = 2'b01,
    CIN_ZERO = 2'b10,
    CIN_ONE  = 2'b11
  } cin_mode_e;
endpackage

// File: rtl/alu_carry_sel.sv
module alu_carry_sel
  import alu_pkg::*;
(
  input  logic       flag_i,
  input  logic [1:0] mode_i,
  output logic       cin_o
);
  always_comb begin
    unique case (cin_mode_e'(mode_i))
      CIN_FLAG: cin_o = flag_i;
      CIN_INV:  cin_o = ~flag_i;
      CIN_ZERO: cin_o = 1'b0;
      default:  cin_o = 1'b1;
    endcase
  end

  always_comb begin
    if (mode_i == 2'b10) AST_CIN_ZERO: assert (cin_o == 1'b0) else $error("cin not 0"); // R3
    if (mode_i == 2'b11) AST_CIN_ONE: assert (cin_o == 1'b1) else $error("cin not 1"); // R4
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         invert_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   carry;

  assign b_eff    = invert_i ? ~b_i : b_i;
  assign carry[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i]   = a_i[i] ^ b_eff[i] ^ carry[i];
    assign carry[i+1] = (a_i[i] & b_eff[i]) | (carry[i] & (a_i[i] ^ b_eff[i]));
  end

  assign cout_o = carry[W];

  always_comb begin
    AST_RIPPLE_SUM: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i}))
      else $error("ripple mismatch"); // R6
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   tt_i,
  output logic [W-1:0] y_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] idx;
    assign idx    = {b_i[i], a_i[i]};
    assign y_o[i] = tt_i[idx];
  end

  always_comb begin
    if (tt_i == 4'b1000) AST_TT_AND: assert (y_o == (a_i & b_i)) else $error("and code"); // R8
    if (tt_i == 4'b0110) AST_TT_XOR: assert (y_o == (a_i ^ b_i)) else $error("xor code"); // R8
  end
endmodule

// File: rtl/alu_zero_det.sv
module alu_zero_det #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] v_i,
  output logic         zero_o
);
  assign zero_o = ~|v_i;
endmodule

// File: rtl/mf_alu.sv
module mf_alu
  import alu_pkg::*;
#(
  parameter int unsigned W = ALU_W
) (
  input  logic [W-1:0] a_op,
  input  logic [W-1:0] b_op,
  input  logic         carry_flag,
  input  logic [1:0]   cin_mode,
  input  logic         sub_en,
  input  logic         arith_en,
  input  logic [3:0]   func_tt,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         neg_flag,
  output logic         zero_flag
);
  localparam int unsigned MSB = W - 1;

  logic         cin_sel;
  logic [W-1:0] sum_w;
  logic [W-1:0] logic_w;

  alu_carry_sel u_cin (
    .flag_i (carry_flag),
    .mode_i (cin_mode),
    .cin_o  (cin_sel)
  );

  alu_addsub #(.W(W)) u_add (
    .a_i      (a_op),
    .b_i      (b_op),
    .invert_i (sub_en),
    .cin_i    (cin_sel),
    .sum_o    (sum_w),
    .cout_o   (carry_out)
  );

  alu_logic_unit #(.W(W)) u_lu (
    .a_i  (a_op),
    .b_i  (b_op),
    .tt_i (func_tt),
    .y_o  (logic_w)
  );

  assign result   = arith_en ? sum_w : logic_w;
  assign neg_flag = result[MSB];

  alu_zero_det #(.W(W)) u_z (
    .v_i    (result),
    .zero_o (zero_flag)
  );

  always_comb begin
    if (zero_flag) AST_ZERO_MEANS_CLEAR: assert (result == '0) else $error("zero flag"); // R10
    if (arith_en && sub_en && cin_mode == 2'b11)
      AST_TRUE_SUB: assert (result == W'(a_op - b_op)) else $error("sub"); // R5
  end
endmodule

// File: tb/mf_alu_tb.sv
module mf_alu_tb;
  localparam int unsigned W = 8;

  typedef struct {
    logic [W-1:0] r;
    logic         c;
    logic         n;
    logic         z;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic [W-1:0] a_op = '0, b_op = '0;
  logic         carry_flag = 1'b0;
  logic [1:0]   cin_mode = 2'b10;
  logic         sub_en = 1'b0, arith_en = 1'b1;
  logic [3:0]   func_tt = 4'b0000;
  logic [W-1:0] result;
  logic         carry_out, neg_flag, zero_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  mf_alu #(.W(W)) u_dut (
    .a_op(a_op), .b_op(b_op), .carry_flag(carry_flag), .cin_mode(cin_mode),
    .sub_en(sub_en), .arith_en(arith_en), .func_tt(func_tt),
    .result(result), .carry_out(carry_out), .neg_flag(neg_flag), .zero_flag(zero_flag)
  );

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic cf,
                       input logic [1:0] cm, input logic sb, input logic ar,
                       input logic [3:0] f, input string tag);
    exp_t e;
    logic cin;
    logic [W:0] s9;
    logic [W-1:0] lg;
    @(posedge clk);
    #1;
    a_op = a; b_op = b; carry_flag = cf; cin_mode = cm;
    sub_en = sb; arith_en = ar; func_tt = f;
    case (cm)
      2'b00: cin = cf;
      2'b01: cin = ~cf;
      2'b10: cin = 1'b0;
      default: cin = 1'b1;
    endcase
    s9 = {1'b0, a} + {1'b0, (sb ? ~b : b)} + {{W{1'b0}}, cin};
    for (int i = 0; i < W; i++) lg[i] = f[{b[i], a[i]}];
    e.r = ar ? s9[W-1:0] : lg;
    e.c = s9[W];
    e.n = e.r[W-1];
    e.z = (e.r == '0);
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (result !== e.r || carry_out !== e.c || neg_flag !== e.n || zero_flag !== e.z) begin
        errors++;
        $display("FAIL %s: got r=%h c=%b n=%b z=%b expected r=%h c=%b n=%b z=%b",
                 e.tag, result, carry_out, neg_flag, zero_flag, e.r, e.c, e.n, e.z);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Idle state after start: all zero inputs, add with cin 0 -> R10 zero flag
    apply(8'h00, 8'h00, 1'b0, 2'b10, 1'b0, 1'b1, 4'h0, "R10 idle");
    // Carry-in modes, carry decides on FF + 00
    for (int cf = 0; cf < 2; cf++) begin
      apply(8'hFF, 8'h00, cf[0], 2'b00, 1'b0, 1'b1, 4'h0, "R1 flag");
      apply(8'hFF, 8'h00, cf[0], 2'b01, 1'b0, 1'b1, 4'h0, "R2 inverted flag");
      apply(8'hFF, 8'h00, cf[0], 2'b10, 1'b0, 1'b1, 4'h0, "R3 forced zero");
      apply(8'hFF, 8'h00, cf[0], 2'b11, 1'b0, 1'b1, 4'h0, "R4 forced one");
    end
    // Random arithmetic, all modes, add and subtract
    for (int k = 0; k < 64; k++) begin
      apply(W'($urandom), W'($urandom), 1'($urandom), 2'(k), 1'(k >> 2), 1'b1, 4'h0, "R5 arith");
      apply(W'($urandom), W'($urandom), 1'b0, 2'b11, 1'b1, 1'b1, 4'h0, "R5 true sub");
    end
    // Carry out while logic mode is selected
    apply(8'hF0, 8'h10, 1'b0, 2'b10, 1'b0, 1'b0, 4'b1110, "R6 carry in logic mode");
    apply(8'hFF, 8'h00, 1'b1, 2'b00, 1'b0, 1'b0, 4'b1000, "R6 flag carry logic mode");
    apply(8'h00, 8'h00, 1'b0, 2'b11, 1'b1, 1'b0, 4'b0110, "R6 sub carry logic mode");
    // All truth tables on random operands
    for (int f = 0; f < 16; f++)
      for (int k = 0; k < 8; k++)
        apply(W'($urandom), W'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 1'b0, 4'(f), "R7 truth table");
    // Named function codes
    apply(8'hCA, 8'h5F, 1'b0, 2'b10, 1'b0, 1'b0, 4'b1000, "R8 and");
    apply(8'hCA, 8'h5F, 1'b0, 2'b10, 1'b0, 1'b0, 4'b1110, "R8 or");
    apply(8'hCA, 8'h5F, 1'b0, 2'b10, 1'b0, 1'b0, 4'b0110, "R8 xor");
    apply(8'hCA, 8'h5F, 1'b0, 2'b10, 1'b0, 1'b0, 4'b1010, "R8 pass a");
    apply(8'hCA, 8'h5F, 1'b0, 2'b10, 1'b0, 1'b0, 4'b0101, "R8 not a");
    // Sign and zero flags
    apply(8'h80, 8'h00, 1'b0, 2'b10, 1'b0, 1'b0, 4'b1010, "R9 sign set");
    apply(8'h7F, 8'h00, 1'b0, 2'b10, 1'b0, 1'b0, 4'b1010, "R9 sign clear");
    apply(8'h5A, 8'hA5, 1'b0, 2'b10, 1'b0, 1'b0, 4'b1000, "R10 zero from and");
    apply(8'h01, 8'h00, 1'b0, 2'b10, 1'b0, 1'b0, 4'b1010, "R10 non-zero");
    // Boundary cases
    apply(8'hFF, 8'h01, 1'b0, 2'b10, 1'b0, 1'b1, 4'h0, "R11 ff plus 01");
    apply(8'h00, 8'h01, 1'b0, 2'b11, 1'b1, 1'b1, 4'h0, "R11 00 minus 01");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule